// File: doc/BRIEF.md
# Word-Serial Montgomery Modular Multiplier

The block computes the Montgomery product X = A·B·R⁻¹ mod N, with R = 2^(128·L), for operands of L 128-bit units. L may be any value from 2 up to a configured maximum (default 8, so 256 to 1024 bits). The work is done one 32-bit word at a time in a word-serial, CIOS-style loop around a pipelined 32×32 multiplier. The multiplier delivers each 64-bit product four clocks after issue, and the sequencer issues a new product every second clock. After the outer loop, a single word-serial pass subtracts N when the accumulator is not below N, so the result is always fully reduced.

Software, or a surrounding sequencer, first writes A, B, N and the word constant n' = −N⁻¹ mod 2^32 through a 128-bit load stream. It then pulses start with the length. The block raises a one-clock done pulse and streams the result back as L 128-bit chunks. Loads use valid/ready, and ready is high only while the block is idle. The result stream uses valid/ready: a chunk that is offered stays on the port unchanged until the consumer takes it. Conversion into and out of Montgomery form, and any exponentiation loop, belong to the caller.

Top module: `montmul_core`

## Requirements
- R1: After reset the block is idle: busy, done and st_valid are low and ld_ready is high.
- R2: A load beat is taken when ld_valid and ld_ready are both high. ld_ready is high only while idle. ld_sel 0 writes A, 1 writes B, 2 writes N, and 3 writes n' from ld_data bits 31:0. Chunk index c covers operand words 4c to 4c+3, and word 4c sits in bits 31:0.
- R3: A start pulse in idle with start_len L in the range 2 to MAX_UNITS begins a 128·L-bit multiply. Any other start_len is ignored, so busy stays low.
- R4: A start pulse while busy has no effect: the running multiply keeps its own length and result.
- R5: For odd N, A < N, B < N and a correct n', the result X satisfies X < N and X·2^(128·L) ≡ A·B (mod N).
- R6: done is high for exactly one clock per multiply. st_valid is already high in that clock.
- R7: The result leaves as exactly L chunks, chunk 0 first, with the word order of R2. st_last is high only on chunk L−1. While st_valid is high and st_ready is low, st_data holds. After the last handshake the block is idle.
- R8: Results stay correct when N is close to 2^(128·L) and A = B = N−1. In this case the accumulator carries into its extra word and the final subtraction is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load beat valid |
| ld_ready | output | 1 | Load beat accepted (idle only) |
| ld_sel | input | 2 | Target: 0 A, 1 B, 2 N, 3 n' |
| ld_idx | input | 3 | 128-bit chunk index within the operand |
| ld_data | input | 128 | Load data, lowest word in bits 31:0 |
| start | input | 1 | Start pulse |
| start_len | input | 4 | Operand length in 128-bit units |
| busy | output | 1 | Multiply or result drain in progress |
| done | output | 1 | One-clock pulse, result ready |
| st_valid | output | 1 | Result chunk valid |
| st_ready | input | 1 | Consumer takes result chunk |
| st_data | output | 128 | Result chunk |
| st_last | output | 1 | Marks the final result chunk |

## Verification
Random odd moduli at random lengths exercise the carry chains of both inner passes at every supported size. A zero multiplicand separates a correct result from a stale accumulator. A = B = 1 exposes a wrong power of R. Moduli of all ones with A = B = N−1 force the top-word carry and the final subtraction, which a design lacking either gets wrong. Out-of-range lengths and a second start during a run show whether the length is latched only once, while a random st_ready pattern shows whether chunk order and st_last survive back-pressure.

// File: rtl/montmul_pkg.sv
package montmul_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_DRAIN,
    ST_SUB,
    ST_OUT
  } state_e;

  // Kind of product travelling through the multiplier pipe
  typedef enum logic [1:0] {
    OP_ACC_A,  // t += A * b_i
    OP_QUOT,   // m = t0 * n'
    OP_ACC_N   // t = (t + m * N) >> word
  } op_e;

  localparam logic [1:0] SEL_A  = 2'd0;
  localparam logic [1:0] SEL_B  = 2'd1;
  localparam logic [1:0] SEL_N  = 2'd2;
  localparam logic [1:0] SEL_NP = 2'd3;
endpackage

// File: rtl/montmul_wordmem.sv
module montmul_wordmem #(
  parameter int WORDS = 32,
  parameter int W     = 32,
  parameter int PW    = 4,
  localparam int AW   = $clog2(WORDS),
  localparam int CAW  = $clog2(WORDS / PW)
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [CAW-1:0]  wr_chunk,
  input  logic [PW*W-1:0] wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [W-1:0]    rd_word
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int p = 0; p < PW; p++) begin
        mem[AW'(wr_chunk) * AW'(PW) + AW'(p)] <= wr_data[p*W +: W];
      end
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/montmul_mulpipe.sv
module montmul_mulpipe #(
  parameter int W   = 32,
  parameter int LAT = 4,
  parameter int TW  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [W-1:0]    in_x,
  input  logic [W-1:0]    in_y,
  input  logic [TW-1:0]   in_tag,
  output logic            out_valid,
  output logic [2*W-1:0]  out_prod,
  output logic [TW-1:0]   out_tag,
  output logic            busy
);
  logic [LAT-1:0] v_q;
  logic [TW-1:0]  tg_q [LAT];
  logic [W-1:0]   x_q, y_q;
  logic [2*W-1:0] p_q [1:LAT-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[LAT-2:0], in_valid};
  end

  always_ff @(posedge clk) begin
    x_q      <= in_x;
    y_q      <= in_y;
    tg_q[0]  <= in_tag;
    p_q[1]   <= {{W{1'b0}}, x_q} * {{W{1'b0}}, y_q};
    for (int k = 1; k < LAT; k++) tg_q[k] <= tg_q[k-1];
    for (int k = 2; k < LAT; k++) p_q[k]  <= p_q[k-1];
  end

  assign out_valid = v_q[LAT-1];
  assign out_prod  = p_q[LAT-1];
  assign out_tag   = tg_q[LAT-1];
  assign busy      = |v_q;
endmodule

// File: rtl/montmul_core.sv
module montmul_core
  import montmul_pkg::*;
#(
  parameter int MAX_BITS    = 1024,
  parameter int WORD_W      = 32,
  parameter int CHUNK_WORDS = 4,
  parameter int MUL_LAT     = 4,
  parameter int ISSUE_GAP   = 2,
  localparam int CHUNK_W    = CHUNK_WORDS * WORD_W,
  localparam int MAX_UNITS  = MAX_BITS / CHUNK_W,
  localparam int LEN_W      = $clog2(MAX_UNITS + 1),
  localparam int IDX_W      = $clog2(MAX_UNITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [1:0]         ld_sel,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [CHUNK_W-1:0] ld_data,
  input  logic               start,
  input  logic [LEN_W-1:0]   start_len,
  output logic               busy,
  output logic               done,
  output logic               st_valid,
  input  logic               st_ready,
  output logic [CHUNK_W-1:0] st_data,
  output logic               st_last
);
  localparam int W    = WORD_W;
  localparam int MAXW = MAX_UNITS * CHUNK_WORDS;
  localparam int AW   = $clog2(MAXW);
  localparam int IW   = $clog2(MAXW + 2);
  localparam int TD   = 1 << IW;
  localparam int TW   = 2 + IW;
  localparam int GW   = $clog2(ISSUE_GAP + 1);

  state_e           st_q;
  op_e              ph_q;
  logic [LEN_W-1:0] len_q, oc_q;
  logic [IW-1:0]    s_q, i_q, j_q;
  logic [GW-1:0]    gap_q;
  logic [W-1:0]     m_q, carry_q, np_q;
  logic             borrow_q, use_diff_q, done_q;
  logic [W-1:0]     t_q [TD];
  logic [W-1:0]     r_q [MAXW];

  logic ld_fire, len_ok;
  assign ld_ready = (st_q == ST_IDLE);
  assign ld_fire  = ld_valid && ld_ready;
  assign len_ok   = (start_len >= LEN_W'(2)) && (start_len <= LEN_W'(MAX_UNITS));

  // ---------------- operand memories: A, B, N ----------------
  logic [W-1:0]  opw [3];
  logic [AW-1:0] opa [3];
  assign opa[0] = j_q[AW-1:0];
  assign opa[1] = i_q[AW-1:0];
  assign opa[2] = j_q[AW-1:0];

  for (genvar g = 0; g < 3; g++) begin : g_mem
    montmul_wordmem #(.WORDS(MAXW), .W(W), .PW(CHUNK_WORDS)) u_mem (
      .clk      (clk),
      .wr_en    (ld_fire && (ld_sel == 2'(g))),
      .wr_chunk (ld_idx),
      .wr_data  (ld_data),
      .rd_addr  (opa[g]),
      .rd_word  (opw[g])
    );
  end

  // ---------------- issue side ----------------
  logic          iss;
  logic [W-1:0]  mx, my;
  assign iss = (st_q == ST_ISSUE) && (gap_q == '0);

  always_comb begin
    case (ph_q)
      OP_ACC_A: begin mx = opw[0]; my = opw[1]; end
      OP_QUOT:  begin mx = t_q[0]; my = np_q;   end
      default:  begin mx = opw[2]; my = m_q;    end
    endcase
  end

  logic           pv, pbusy;
  logic [2*W-1:0] pprod;
  logic [TW-1:0]  ptag;

  montmul_mulpipe #(.W(W), .LAT(MUL_LAT), .TW(TW)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (iss),
    .in_x      (mx),
    .in_y      (my),
    .in_tag    ({ph_q, j_q}),
    .out_valid (pv),
    .out_prod  (pprod),
    .out_tag   (ptag),
    .busy      (pbusy)
  );

  // ---------------- retire side ----------------
  op_e            rop;
  logic [IW-1:0]  rj, s_m1, s_p1;
  logic [2*W-1:0] acc;
  logic [W:0]     tail, dif;
  logic           rlast;

  assign rop   = op_e'(ptag[TW-1:IW]);
  assign rj    = ptag[IW-1:0];
  assign s_m1  = s_q - IW'(1);
  assign s_p1  = s_q + IW'(1);
  assign rlast = (rj == s_m1);
  assign acc   = {{W{1'b0}}, t_q[rj]} + pprod + {{W{1'b0}}, carry_q};
  assign tail  = {1'b0, t_q[s_q]} + {1'b0, acc[2*W-1:W]};
  assign dif   = {1'b0, t_q[j_q]} - {1'b0, opw[2]} - {{W{1'b0}}, borrow_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      ph_q       <= OP_ACC_A;
      len_q      <= '0;
      oc_q       <= '0;
      s_q        <= '0;
      i_q        <= '0;
      j_q        <= '0;
      gap_q      <= '0;
      m_q        <= '0;
      carry_q    <= '0;
      np_q       <= '0;
      borrow_q   <= 1'b0;
      use_diff_q <= 1'b0;
      done_q     <= 1'b0;
      for (int k = 0; k < TD; k++) t_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      if (ld_fire && ld_sel == SEL_NP) np_q <= ld_data[W-1:0];

      if (pv) begin
        case (rop)
          OP_ACC_A: begin
            t_q[rj] <= acc[W-1:0];
            carry_q <= acc[2*W-1:W];
            if (rlast) begin
              t_q[s_q]  <= tail[W-1:0];
              t_q[s_p1] <= {{(W-1){1'b0}}, tail[W]};
            end
          end
          OP_QUOT: m_q <= pprod[W-1:0];
          default: begin
            if (rj != '0) t_q[rj - IW'(1)] <= acc[W-1:0];
            carry_q <= acc[2*W-1:W];
            if (rlast) begin
              t_q[s_m1] <= tail[W-1:0];
              t_q[s_q]  <= t_q[s_p1] + {{(W-1){1'b0}}, tail[W]};
              t_q[s_p1] <= '0;
            end
          end
        endcase
      end

      case (st_q)
        ST_IDLE: begin
          if (start && len_ok) begin
            len_q   <= start_len;
            s_q     <= IW'(start_len * CHUNK_WORDS);
            i_q     <= '0;
            j_q     <= '0;
            gap_q   <= '0;
            carry_q <= '0;
            ph_q    <= OP_ACC_A;
            for (int k = 0; k < TD; k++) t_q[k] <= '0;
            st_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (gap_q == '0) begin
            gap_q <= GW'(ISSUE_GAP - 1);
            if (ph_q == OP_QUOT || j_q == s_m1) st_q <= ST_DRAIN;
            else                                j_q  <= j_q + IW'(1);
          end else begin
            gap_q <= gap_q - GW'(1);
          end
        end
        ST_DRAIN: begin
          if (!pbusy) begin
            j_q     <= '0;
            gap_q   <= '0;
            carry_q <= '0;
            case (ph_q)
              OP_ACC_A: begin ph_q <= OP_QUOT;  st_q <= ST_ISSUE; end
              OP_QUOT:  begin ph_q <= OP_ACC_N; st_q <= ST_ISSUE; end
              default: begin
                if (i_q == s_m1) begin
                  borrow_q <= 1'b0;
                  st_q     <= ST_SUB;
                end else begin
                  i_q  <= i_q + IW'(1);
                  ph_q <= OP_ACC_A;
                  st_q <= ST_ISSUE;
                end
              end
            endcase
          end
        end
        ST_SUB: begin
          borrow_q <= dif[W];
          if (j_q == s_m1) begin
            use_diff_q <= (t_q[s_q] != '0) || !dif[W];
            done_q     <= 1'b1;
            oc_q       <= '0;
            st_q       <= ST_OUT;
          end else begin
            j_q <= j_q + IW'(1);
          end
        end
        ST_OUT: begin
          if (st_ready) begin
            if (oc_q == len_q - LEN_W'(1)) st_q <= ST_IDLE;
            else                           oc_q <= oc_q + LEN_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // difference words of the final subtraction
  always_ff @(posedge clk) begin
    if (st_q == ST_SUB) r_q[j_q[AW-1:0]] <= dif[W-1:0];
  end

  // ---------------- result stream ----------------
  for (genvar k = 0; k < CHUNK_WORDS; k++) begin : g_out
    logic [IW-1:0] ow;
    assign ow = IW'(oc_q) * IW'(CHUNK_WORDS) + IW'(k);
    assign st_data[k*W +: W] = use_diff_q ? r_q[ow[AW-1:0]] : t_q[ow];
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = done_q;
  assign st_valid = (st_q == ST_OUT);
  assign st_last  = st_valid && (oc_q == len_q - LEN_W'(1));
endmodule

// File: rtl/montmul_chk.sv
module montmul_chk #(
  parameter int MAX_UNITS = 8,
  parameter int LEN_W     = 4,
  parameter int CHUNK_W   = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [LEN_W-1:0]   start_len,
  input logic               busy,
  input logic               done,
  input logic               ld_ready,
  input logic               st_valid,
  input logic               st_ready,
  input logic               st_last,
  input logic [CHUNK_W-1:0] st_data
);
  logic bad_len;
  assign bad_len = (start_len < LEN_W'(2)) || (start_len > LEN_W'(MAX_UNITS));

  // R2
  ld_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ld_ready);

  // R3
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && bad_len) |=> !busy);

  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(st_valid && st_ready && st_last)) |=> busy);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> st_valid);

  // R7
  st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data)));

  // R7
  st_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_last) |=> !busy);
endmodule

bind montmul_core montmul_chk #(
  .MAX_UNITS (MAX_UNITS),
  .LEN_W     (LEN_W),
  .CHUNK_W   (CHUNK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .start_len (start_len),
  .busy      (busy),
  .done      (done),
  .ld_ready  (ld_ready),
  .st_valid  (st_valid),
  .st_ready  (st_ready),
  .st_last   (st_last),
  .st_data   (st_data)
);

// File: tb/montmul_core_bench.sv
`timescale 1ns/1ps
module montmul_core_bench;
  localparam int MB = 1024;
  localparam int XW = 2 * MB + 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ld_valid = 1'b0;
  logic         ld_ready;
  logic [1:0]   ld_sel = '0;
  logic [2:0]   ld_idx = '0;
  logic [127:0] ld_data = '0;
  logic         start = 1'b0;
  logic [3:0]   start_len = '0;
  logic         busy, done, st_valid, st_last;
  logic         st_ready = 1'b0;
  logic [127:0] st_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  montmul_core u_montmul_core (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_sel(ld_sel), .ld_idx(ld_idx), .ld_data(ld_data), .start(start),
    .start_len(start_len), .busy(busy), .done(done), .st_valid(st_valid),
    .st_ready(st_ready), .st_data(st_data), .st_last(st_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [MB-1:0] act, input logic [MB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nprime(input logic [31:0] n0);
    logic [31:0] x = n0;
    for (int k = 0; k < 5; k++) x = x * (32'd2 - n0 * x);
    return -x;
  endfunction

  function automatic logic [MB-1:0] rand_wide(input int len);
    logic [MB-1:0] v = '0;
    for (int w = 0; w < 4 * len; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic load_op(input logic [1:0] sel, input int len, input logic [MB-1:0] v);
    for (int c = 0; c < len; c++) begin
      @(negedge clk);
      ld_valid = 1'b1; ld_sel = sel; ld_idx = 3'(c); ld_data = v[c*128 +: 128];
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_mul(input int len, input logic [MB-1:0] a, input logic [MB-1:0] b,
                         input logic [MB-1:0] n, input int poke_len, input string req);
    logic [MB-1:0] res = '0;
    logic [XW-1:0] lhs, rhs;
    int  donecnt = 0, k = 0, guard = 0;
    bit  got = 0, lastbad = 0, stall_ok = 1, valid_at_done = 0;
    load_op(2'd0, len, a);
    load_op(2'd1, len, b);
    load_op(2'd2, len, n);
    @(negedge clk);
    ld_valid = 1'b1; ld_sel = 2'd3; ld_idx = '0; ld_data = 128'(nprime(n[31:0]));
    @(negedge clk);
    ld_valid = 1'b0; start = 1'b1; start_len = 4'(len);
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 40000 && !got; c++) begin
      start = (poke_len != 0) && (c == 5);
      if (c == 5) start_len = 4'(poke_len);
      @(negedge clk);
      if (c == 5 && ld_ready) stall_ok = 0;
      if (done) begin got = 1; donecnt++; valid_at_done = st_valid; end
    end
    start = 1'b0;
    chk(got, "R6", "done seen", MB'(got), MB'(1));
    chk(valid_at_done, "R6", "st_valid with done", MB'(valid_at_done), MB'(1));
    chk(stall_ok, "R2", "ld_ready low while busy", MB'(!stall_ok), MB'(0));
    while (got && k < len && guard < 5000) begin
      bit r = ($urandom % 4) != 0;
      st_ready = r;
      if (st_valid && r) begin
        res[k*128 +: 128] = st_data;
        if (st_last != (k == len - 1)) lastbad = 1;
        k++;
      end
      @(negedge clk);
      guard++;
      if (done) donecnt++;
    end
    st_ready = 1'b0;
    chk(donecnt == 1, "R6", "done pulse count", MB'(donecnt), MB'(1));
    chk(k == len && !lastbad, {"R7 ", req}, "chunks and st_last", MB'(k), MB'(len));
    chk(!busy, "R7", "idle after last chunk", MB'(busy), MB'(0));
    lhs = (XW'(res) << (128 * len)) % XW'(n);
    rhs = (XW'(a) * XW'(b)) % XW'(n);
    chk(res < n && lhs == rhs, {"R5 ", req}, "montgomery residue", lhs[MB-1:0], rhs[MB-1:0]);
    if (a == '0 || b == '0) chk(res == '0, "R5", "zero operand", res, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [MB-1:0] a, b, n, full;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!busy, "R1", "busy after reset", MB'(busy), '0);
    chk(!done, "R1", "done after reset", MB'(done), '0);
    chk(!st_valid, "R1", "st_valid after reset", MB'(st_valid), '0);
    chk(ld_ready, "R1", "ld_ready after reset", MB'(ld_ready), MB'(1));

    // R3: out-of-range lengths
    foreach (full[q]) full[q] = 1'b0;
    for (int t = 0; t < 3; t++) begin
      int bl = (t == 0) ? 0 : (t == 1) ? 1 : 9;
      @(negedge clk); start = 1'b1; start_len = 4'(bl);
      @(negedge clk); start = 1'b0;
      chk(!busy, "R3", "bad length ignored", MB'(busy), '0);
    end

    // R5: zero multiplicand, minimum length
    n = rand_wide(2); n[0] = 1'b1; n[255] = 1'b1;
    run_mul(2, '0, rand_wide(2) % n, n, 0, "zero");
    // R5: A = B = 1
    n = rand_wide(2); n[0] = 1'b1;
    run_mul(2, MB'(1), MB'(1), n, 0, "unit");
    // R8: all-ones modulus at max length
    n = '1;
    run_mul(8, n - 1, n - 1, n, 0, "R8 max");
    // R8: all-ones modulus at odd length
    n = '0; n[383:0] = '1;
    run_mul(3, n - 1, n - 1, n, 0, "R8 len3");
    // R4: start poked while busy with a different length
    n = rand_wide(4); n[0] = 1'b1;
    run_mul(4, rand_wide(4) % n, rand_wide(4) % n, n, 2, "R4 poke");
    // random lengths and operands
    for (int t = 0; t < 8; t++) begin
      int len = 2 + int'($urandom % 7);
      n = rand_wide(len); n[0] = 1'b1;
      if ($urandom % 2) n[128*len-1] = 1'b1;
      a = rand_wide(len) % n;
      b = rand_wide(len) % n;
      run_mul(len, a, b, n, 0, "random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule